// File: doc/BRIEF.md
# Monochrome TMDS Pair Encoder

This block turns a stream of packed 1-bit black/white pixels into 10-bit TMDS channel symbols at full horizontal resolution. No running disparity is tracked. Pixels at even x positions get one of two fixed symbols whose imbalance is -8. Pixels at odd x positions get one of two fixed symbols whose imbalance is +8. The balance therefore returns to zero after every even/odd pair, and each symbol depends only on the pixel's colour bit and the parity of its position.

A 32-pixel word is accepted on a valid/ready input. The block then emits sixteen 20-bit output words on a valid/ready output, one per pixel pair. Each output word holds the even pixel's symbol in bits 9:0 and the odd pixel's symbol in bits 19:10. A parameter selects whether the first pixel of an input word is its least or its most significant bit. Lines must contain an even number of pixels and start at an even position. Serialisation, control periods and the other colour channels live elsewhere.

Top module: `mono_pair_encoder`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o is 0 and in_ready_o is 1 until a word has been accepted.
- R2: The even-position symbol in out_data_o[9:0] is 10'h100 for a black pixel (bit value 0) and 10'h200 for a white pixel (bit value 1).
- R3: The odd-position symbol in out_data_o[19:10] is 10'h1FF for a black pixel and 10'h2FF for a white pixel. An all-black pair reads 20'h7FD00 and an all-white pair reads 20'hBFE00.
- R4: With BIT_REV = 0, output pair n (n = 0..15) of a word takes its even pixel from input bit 2n and its odd pixel from bit 2n+1.
- R5: With BIT_REV = 1, output pair n takes its even pixel from input bit 31-2n and its odd pixel from bit 30-2n.
- R6: Each accepted word yields exactly 16 output pairs, in order. While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value.
- R7: in_ready_o falls in the cycle after a word is accepted. It stays low until the 16th pair has been taken, and it is high again in the following cycle.
- R8: Over the emitted symbol stream, the running disparity (ones minus zeros) is -8 after each even symbol and 0 after each pair.
- R9: in_valid_i and in_data_i have no effect while in_ready_o is low. The pairs of the word in progress are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Packed pixel word offered |
| in_ready_o | output | 1 | Block can take a word |
| in_data_i | input | 32 | 32 packed pixels, 1 = white |
| out_valid_o | output | 1 | Symbol pair available |
| out_ready_i | input | 1 | Downstream takes the pair |
| out_data_o | output | 20 | Odd symbol in 19:10, even symbol in 9:0 |

## Verification
A wrong pair count or a stale shift position appears at the ports within one word: the output stream runs short or long, or it repeats or skips pixels, and in_ready_o returns at the wrong cycle. A corrupted colour mapping or parity slot is visible on the very pair it affects. It shows either as a symbol outside the allowed set or as a nonzero disparity at the end of that pair. The bench models the stream as a queue of expected pairs for both pixel orders and compares it on every clock. Random backpressure and ignored input writes are applied during the run.

// File: rtl/mono_pair_pkg.sv
package mono_pair_pkg;
  localparam int SYM_W  = 10;
  localparam int PAIR_W = 2 * SYM_W;

  typedef logic [SYM_W-1:0] sym_t;

  // even slot: imbalance -8, odd slot: +8
  localparam sym_t SYM_EVEN_BLACK = 10'h100;
  localparam sym_t SYM_EVEN_WHITE = 10'h200;
  localparam sym_t SYM_ODD_BLACK  = 10'h1FF;
  localparam sym_t SYM_ODD_WHITE  = 10'h2FF;
endpackage

// File: rtl/mono_bit_order.sv
module mono_bit_order #(
  parameter int WORD_W  = 32,
  parameter bit BIT_REV = 1'b0
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  // word_o[0] is always the first pixel
  generate
    if (BIT_REV) begin : g_rev
      for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign word_o[i] = word_i[WORD_W-1-i];
      end
    end else begin : g_fwd
      assign word_o = word_i;
    end
  endgenerate
endmodule

// File: rtl/mono_pair_map.sv
module mono_pair_map
  import mono_pair_pkg::*;
(
  input  logic [1:0]        pix_i,
  output logic [PAIR_W-1:0] pair_o
);
  sym_t sym [2];

  generate
    for (genvar s = 0; s < 2; s++) begin : g_slot
      if (s == 0) begin : g_even
        assign sym[s] = pix_i[s] ? SYM_EVEN_WHITE : SYM_EVEN_BLACK;
      end else begin : g_odd
        assign sym[s] = pix_i[s] ? SYM_ODD_WHITE : SYM_ODD_BLACK;
      end
      assign pair_o[s*SYM_W +: SYM_W] = sym[s];
    end
  endgenerate
endmodule

// File: rtl/mono_word_seq.sv
module mono_word_seq #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [1:0]        pix_o
);
  localparam int PAIRS = WORD_W / 2;
  localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAIRS - 1);

  logic [WORD_W-1:0] buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (load_i && !full_q) begin
      buf_q  <= word_i;
      cnt_q  <= '0;
      full_q <= 1'b1;
    end else if (take_i && full_q) begin
      buf_q <= buf_q >> 2;
      if (cnt_q == LAST_IDX) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign full_o = full_q;
  assign pix_o  = buf_q[1:0];
endmodule

// File: rtl/mono_pair_encoder.sv
module mono_pair_encoder
  import mono_pair_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter bit BIT_REV = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PAIR_W-1:0] out_data_o
);
  logic [WORD_W-1:0] ordered;
  logic              full;
  logic [1:0]        pix;

  mono_bit_order #(.WORD_W(WORD_W), .BIT_REV(BIT_REV)) u_order (
    .word_i (in_data_i),
    .word_o (ordered)
  );

  mono_word_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i),
    .word_i (ordered),
    .take_i (out_ready_i),
    .full_o (full),
    .pix_o  (pix)
  );

  mono_pair_map u_map (
    .pix_i  (pix),
    .pair_o (out_data_o)
  );

  assign in_ready_o  = !full;
  assign out_valid_o = full;
endmodule

// File: rtl/mono_pair_encoder_chk.sv
module mono_pair_encoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [19:0] out_data_o
);
  // R7
  busy_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && !in_ready_o);

  // R7
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o && !out_valid_o);

  // R6
  stall_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R8
  slot_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones(out_data_o[9:0]) == 1) &&
                    ($countones(out_data_o[19:10]) == 9));

  // R2
  even_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o[9:0] == 10'h100) || (out_data_o[9:0] == 10'h200));

  // R3
  odd_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o[19:10] == 10'h1FF) || (out_data_o[19:10] == 10'h2FF));
endmodule

bind mono_pair_encoder mono_pair_encoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/mono_pair_encoder_test.sv
`timescale 1ns/1ps
module mono_pair_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        rand_bp = 1'b0;
  logic        rdy0, rdy1, vld0, vld1;
  logic [19:0] dat0, dat1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mono_pair_encoder #(.BIT_REV(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy0),
    .in_data_i(in_data), .out_valid_o(vld0), .out_ready_i(out_ready), .out_data_o(dat0));

  mono_pair_encoder #(.BIT_REV(1'b1)) uut_rev (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy1),
    .in_data_i(in_data), .out_valid_o(vld1), .out_ready_i(out_ready), .out_data_o(dat1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] sym(input bit odd, input bit white);
    if (!odd) return white ? 10'h200 : 10'h100;
    return white ? 10'h2FF : 10'h1FF;
  endfunction

  // reference model
  logic [19:0] q0[$];
  logic [19:0] q1[$];
  bit m_full = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q0.delete(); q1.delete(); m_full = 1'b0;
    end else if (m_full && out_ready) begin
      void'(q0.pop_front());
      void'(q1.pop_front());
      if (q0.size() == 0) m_full = 1'b0;
    end else if (!m_full && in_valid) begin
      for (int n = 0; n < 16; n++) begin
        q0.push_back({sym(1, in_data[2*n+1]), sym(0, in_data[2*n])});
        q1.push_back({sym(1, in_data[30-2*n]), sym(0, in_data[31-2*n])});
      end
      m_full = 1'b1;
    end
  end

  // compare away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(vld0 == 1'b0 && vld1 == 1'b0, "R1 out_valid in reset", {vld0, vld1}, 0);
      chk(rdy0 && rdy1, "R1 in_ready in reset", {rdy0, rdy1}, 2'b11);
    end else if (!done) begin
      chk(rdy0 == !m_full && rdy1 == !m_full, "R7 in_ready", {rdy0, rdy1}, {2{!m_full}});
      chk(vld0 == m_full && vld1 == m_full, "R6 out_valid", {vld0, vld1}, {2{m_full}});
      if (m_full && vld0 && vld1) begin
        chk(dat0[9:0] == q0[0][9:0], "R2 R4 R9 even symbol", dat0, q0[0]);
        chk(dat0[19:10] == q0[0][19:10], "R3 R4 R9 odd symbol", dat0, q0[0]);
        chk(dat1 == q1[0], "R5 reversed pair", dat1, q1[0]);
      end
      if (vld0 && out_ready) begin
        int e0, e1;
        e0 = 2 * $countones(dat0[9:0]) - 10;
        e1 = e0 + 2 * $countones(dat0[19:10]) - 10;
        chk(e0 == -8 && e1 == 0, "R8 disparity", e1, 0);
      end
      if (vld1 && out_ready) begin
        int e0, e1;
        e0 = 2 * $countones(dat1[9:0]) - 10;
        e1 = e0 + 2 * $countones(dat1[19:10]) - 10;
        chk(e0 == -8 && e1 == 0, "R8 disparity reversed", e1, 0);
      end
    end
  end

  always @(negedge clk) out_ready <= rand_bp ? ($urandom_range(3) != 0) : 1'b1;

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!m_full) @(negedge clk);
    // R9: junk offered while busy
    in_data = 32'hDEAD_BEEF ^ w;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    while (m_full) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy0 && !vld0, "R1 idle after reset", {rdy0, vld0}, 2'b10);
    send(32'h0000_0000);
    send(32'hFFFF_FFFF);
    send(32'h0000_0001);
    send(32'h8000_0000);
    send(32'hAAAA_AAAA);
    send(32'h1234_5678);
    rand_bp = 1'b1;
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr);
    end
    rand_bp = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule